// File: doc/BRIEF.md
# Subtractive Decode Claim Timer

This block sits beside a bridge on a shared, PCI-style parallel bus and decides, for every transaction, whether the bridge should take it by subtractive decode. It has no address map. It only notes when a transaction starts, which is the first clock with FRAME# low after the bus was idle. It then counts clocks and watches the DEVSEL# line that positively decoding targets drive. If no other target claims the transaction before the selected decode window closes, the block drives its own DEVSEL# low. It also sends a one-clock forward request toward a slower secondary bus. That request carries the address and command captured at the start of the transaction.

A mode input selects the window. The slow setting claims on the clock after the slow-claim slot. The medium setting claims one clock earlier, which shortens every transaction that falls through to the secondary bus. The mode is captured when the transaction starts, so a change during a transaction takes effect only from the next one.

Top module: `subtractive_claim_timer`

## Requirements
- R1: A synchronous active-high reset puts the block in idle, with devsel_n_out high (1) and forward_req low. This holds on the clock after reset is released and also when reset is applied in the middle of a claim.
- R2: In slow mode (mode_slow=1 at the start clock), counting the start clock as 0, the block drives devsel_n_out low after clock edge 4, provided devsel_n_in was high at edges 1 through 4 and the bus did not go idle.
- R3: In medium mode (mode_slow=0 at the start clock), the same claim happens after edge 3, exactly one clock earlier than in slow mode.
- R4: If devsel_n_in is sampled low (0) at any edge from 1 through the claim edge, the block does not claim and does not forward. It stays out of the transaction until an edge where frame_n and irdy_n are both sampled high.
- R5: Once devsel_n_out is low, it stays low until the first edge where frame_n and irdy_n are both sampled high, and it is high after that edge.
- R6: forward_req is high for exactly one clock, in the first clock that devsel_n_out is low. During that clock fwd_addr and fwd_cmd equal the ad and cbe values sampled at edge 0.
- R7: mode_slow is sampled only at the start edge of a transaction. Changes at any later edge do not move that transaction's claim edge.
- R8: If frame_n and irdy_n are both sampled high before the claim edge, the transaction ends with no claim and no forward request.
- R9: A new transaction is recognised at the first edge in idle where frame_n is sampled low. This includes the edge right after the previous transaction ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_slow | input | 1 | 1 selects the slow decode window, 0 selects the medium one |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| devsel_n_in | input | 1 | DEVSEL# as driven by other targets, active low |
| ad | input | ADDR_W | Address/data lines |
| cbe | input | CMD_W | Command/byte-enable lines |
| devsel_n_out | output | 1 | This block's claim, active low |
| forward_req | output | 1 | One-clock request to forward the transaction to the secondary bus |
| fwd_addr | output | ADDR_W | Address captured at the start of the transaction |
| fwd_cmd | output | CMD_W | Command captured at the start of the transaction |

## Verification
A corrupted clock count or a mode captured on the wrong edge shows up as devsel_n_out falling one clock early or late, on the very transaction where the fault occurs. A state that misses a claim by another target causes a second DEVSEL# driver and a spurious forward_req in the same clock. A state that fails to leave its claim shows up as devsel_n_out still low on the clock after the bus goes idle. The bench compares both outputs on every clock against an independent per-clock model, so each of these faults is reported within one clock of its first visible effect.

// File: rtl/subtractive_claim_timer.sv
module subtractive_claim_timer #(
  parameter int ADDR_W     = 32,
  parameter int CMD_W      = 4,
  parameter int MED_CLAIM  = 3,
  parameter int SLOW_CLAIM = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_slow,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              devsel_n_in,
  input  logic [ADDR_W-1:0] ad,
  input  logic [CMD_W-1:0]  cbe,
  output logic              devsel_n_out,
  output logic              forward_req,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [CMD_W-1:0]  fwd_cmd
);
  localparam int CNT_W = $clog2(SLOW_CLAIM + 1);

  typedef enum logic [1:0] {S_IDLE, S_COUNT, S_CLAIM, S_SKIP} st_t;

  st_t            st;
  logic [CNT_W-1:0] cnt;
  logic           slow_q;

  wire             bus_idle = frame_n & irdy_n;
  wire [CNT_W-1:0] cnt_nx   = cnt + 1'b1;
  wire [CNT_W-1:0] limit    = slow_q ? CNT_W'(SLOW_CLAIM) : CNT_W'(MED_CLAIM);

  assign devsel_n_out = (st != S_CLAIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt         <= '0;
      slow_q      <= 1'b0;
      forward_req <= 1'b0;
      fwd_addr    <= '0;
      fwd_cmd     <= '0;
    end else begin
      forward_req <= 1'b0;
      case (st)
        S_IDLE:
          if (!frame_n) begin
            st       <= S_COUNT;
            cnt      <= '0;
            slow_q   <= mode_slow;
            fwd_addr <= ad;
            fwd_cmd  <= cbe;
          end
        S_COUNT:
          if (bus_idle)              st <= S_IDLE;
          else if (!devsel_n_in)     st <= S_SKIP;
          else if (cnt_nx == limit) begin
            st          <= S_CLAIM;
            forward_req <= 1'b1;
          end else                   cnt <= cnt_nx;
        S_CLAIM, S_SKIP:
          if (bus_idle) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (devsel_n_out && !forward_req));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst) forward_req |=> !forward_req);
  a_r6_pulse_with_claim: assert property (@(posedge clk) disable iff (rst) forward_req |-> !devsel_n_out);
  a_r6_claim_forwarded: assert property (@(posedge clk) disable iff (rst) $fell(devsel_n_out) |-> forward_req);
  a_r5_hold_claim: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n_out && !(frame_n && irdy_n)) |=> !devsel_n_out);
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n_out && frame_n && irdy_n) |=> devsel_n_out);
  a_r4_yield: assert property (@(posedge clk) disable iff (rst)
    (devsel_n_out && !devsel_n_in) |=> (devsel_n_out && !forward_req));
endmodule

// File: tb/subtractive_claim_timer_tb_top.sv
module subtractive_claim_timer_tb_top;
  localparam int AW = 32, CW = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic mode_slow = 1'b0, frame_n = 1'b1, irdy_n = 1'b1, devsel_n_in = 1'b1;
  logic [AW-1:0] ad = '0;
  logic [CW-1:0] cbe = '0;
  logic devsel_n_out, forward_req;
  logic [AW-1:0] fwd_addr;
  logic [CW-1:0] fwd_cmd;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "";

  // bench model: 0 idle, 1 counting, 2 claimed, 3 yielded
  int m_st = 0, m_cnt = 0;
  bit m_slow = 0, m_fwd = 0;
  logic [AW-1:0] m_addr = '0;
  logic [CW-1:0] m_cmd = '0;

  subtractive_claim_timer #(.ADDR_W(AW), .CMD_W(CW)) dut_i (
    .clk(clk), .rst(rst), .mode_slow(mode_slow), .frame_n(frame_n), .irdy_n(irdy_n),
    .devsel_n_in(devsel_n_in), .ad(ad), .cbe(cbe), .devsel_n_out(devsel_n_out),
    .forward_req(forward_req), .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd));

  always #4 clk = ~clk;

  function automatic int claim_edge(bit slow);
    return slow ? 4 : 3;
  endfunction

  function automatic string auto_tag();
    if (tag != "") return tag;
    if (m_fwd) return "R6";
    if (m_st == 2) return "R5";
    if (m_st == 3) return "R4";
    return m_slow ? "R2" : "R3";
  endfunction

  task automatic model_step();
    bit idle = frame_n && irdy_n;
    m_fwd = 0;
    if (rst) begin m_st = 0; m_cnt = 0; return; end
    case (m_st)
      0: if (!frame_n) begin m_st = 1; m_cnt = 0; m_slow = mode_slow; m_addr = ad; m_cmd = cbe; end
      1: begin
           m_cnt++;
           if (idle) m_st = 0;
           else if (!devsel_n_in) m_st = 3;
           else if (m_cnt == claim_edge(m_slow)) begin m_st = 2; m_fwd = 1; end
         end
      default: if (idle) m_st = 0;
    endcase
  endtask

  task automatic check(string t, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", t, what, act, exp, cycles);
    end
  endtask

  // advance one clock: model on edge, compare outputs at the following negedge
  task automatic step();
    @(posedge clk);
    model_step();
    cycles++;
    @(negedge clk);
    check(auto_tag(), devsel_n_out, (m_st == 2) ? 1'b0 : 1'b1, "devsel_n_out");
    check(auto_tag(), forward_req, m_fwd, "forward_req");
    if (m_fwd) begin
      check("R6", fwd_addr, m_addr, "fwd_addr");
      check("R6", fwd_cmd, m_cmd, "fwd_cmd");
    end
  endtask

  task automatic drive(bit f, bit i, bit d);
    frame_n = f; irdy_n = i; devsel_n_in = d;
    ad = $urandom; cbe = 4'($urandom);
  endtask

  // one transaction: frame low for flen clocks, others claim from clock oth (0 = never)
  task automatic txn(bit slow, int flen, int oth, bit flip, int gap);
    for (int k = 0; k < gap; k++) begin drive(1, 1, 1); if (flip) mode_slow = $urandom; step(); end
    mode_slow = slow;
    for (int k = 0; k < flen; k++) begin
      drive(0, (k == 0), !(oth != 0 && k >= oth));
      if (flip && k > 0) mode_slow = ~mode_slow;
      step();
    end
    drive(1, 0, !(oth != 0 && flen >= oth));
    step();
    drive(1, 1, 1);
    step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    drive(1, 1, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1", devsel_n_out, 1'b1, "devsel_n_out after reset");
    check("R1", forward_req, 1'b0, "forward_req after reset");

    tag = "R3"; txn(0, 8, 0, 0, 1);
    tag = "R2"; txn(1, 8, 0, 0, 1);
    tag = "R4";
    for (int o = 1; o <= 4; o++) begin txn(0, 7, o, 0, 1); txn(1, 7, o, 0, 1); end
    tag = "R5"; txn(1, 8, 5, 0, 1); txn(0, 4, 0, 0, 0);
    tag = "R8"; txn(0, 2, 0, 0, 1); txn(1, 3, 0, 0, 1);
    tag = "R7"; txn(0, 7, 0, 1, 1); txn(1, 7, 0, 1, 1);
    tag = "R9"; txn(0, 6, 0, 0, 0); txn(1, 6, 0, 0, 0); txn(0, 6, 0, 0, 0);

    tag = "R1";
    mode_slow = 0; drive(0, 1, 1); step();
    for (int k = 0; k < 4; k++) begin drive(0, 0, 1); step(); end
    rst = 1'b1; step(); rst = 1'b0; drive(1, 1, 1); step();
    check("R1", devsel_n_out, 1'b1, "devsel_n_out after mid-claim reset");

    tag = "";
    for (int n = 0; n < 400; n++)
      txn($urandom_range(0, 1), $urandom_range(1, 9), $urandom_range(0, 6),
          $urandom_range(0, 1), $urandom_range(0, 3));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule